// File: doc/BRIEF.md
# Paged Program Address Unit

This block generates the instruction fetch address of a small 8-bit controller. It holds a 13-bit program counter that spans an 8K-word program store. The store is split into eight 1K-word pages. The page number, which forms the top three address bits, comes from a separate page register and not from the instruction word. Once per instruction cycle the unit takes the decoded flow-control strobes and picks the next address. The choices are sequential increment, absolute jump, subroutine call, return, a load of the accumulator into the counter, an accumulator-relative add, and interrupt entry.

Calls and interrupt entry push their return address onto a 16-entry circular hardware stack. All return forms pop that stack. On interrupt entry the unit also keeps a one-level shadow copy of the accumulator, the status register and the page register. A return from interrupt raises a one-cycle restore pulse while the saved bytes are presented, so that the register file can copy them back.

Top module: `pgpc_unit`

## Requirements
- R1: While `rst_n` is low, on each clock edge the counter becomes 0x0000, `restore_o` becomes 0, all three shadow outputs become 0x00, and every stack slot and the stack pointer become zero.
- R2: When `adv_i` is high and no strobe is set, the counter steps by one and wraps from 0x1FFF to 0x0000. When `adv_i` is low, the counter holds and every strobe is ignored.
- R3: A jump loads `{page_i[2:0], tgt_i[9:0]}` into the counter.
- R4: A call loads the same address as a jump. It pushes the counter value plus one onto the stack, so that a later return resumes after the call.
- R5: A plain return (`ret_i`) or an interrupt return (`reti_i`) loads the whole counter from the most recently pushed entry and pops it. Nested calls therefore unwind last-in first-out.
- R6: A move-to-counter sets PC[7:0] to `acc_i`, forces PC[9:8] to 0 and keeps PC[12:10].
- R7: An add-to-counter sets the counter to (PC + `acc_i`) modulo 8192 and then forces bits 9:8 to 0. A carry out of bit 9 therefore reaches the page bits.
- R8: Interrupt entry (`irq_i`) loads 0x0008 and pushes the current, not incremented, counter value. It overrides every other strobe in the same cycle.
- R9: Interrupt entry captures `acc_i`, `status_i` and `page_i` into the shadow outputs. After a return taken through `reti_i`, `restore_o` is high for exactly the next cycle. A plain return never raises it.
- R10: When several non-interrupt strobes are set together, the unit honours the first one in this order: return, call, jump, move, add.
- R11: The stack pointer wraps modulo 16. The seventeenth push overwrites the oldest entry. A pop past the bottom returns whatever that slot holds, with no error indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_i | input | 1 | Instruction-cycle enable |
| irq_i | input | 1 | Interrupt entry strobe |
| ret_i | input | 1 | Plain return strobe (also the return-with-literal form) |
| reti_i | input | 1 | Return-from-interrupt strobe |
| call_i | input | 1 | Call strobe |
| jmp_i | input | 1 | Jump strobe |
| ldpc_i | input | 1 | Move accumulator into counter strobe |
| addpc_i | input | 1 | Add accumulator to counter strobe |
| tgt_i | input | 10 | In-page target from the instruction operand |
| acc_i | input | 8 | Accumulator value |
| status_i | input | 8 | Status register value |
| page_i | input | 8 | Page register value; bits 2:0 select the page |
| pc_o | output | 13 | Fetch address |
| restore_o | output | 1 | One-cycle restore pulse after an interrupt return |
| sh_acc_o | output | 8 | Saved accumulator |
| sh_status_o | output | 8 | Saved status |
| sh_page_o | output | 8 | Saved page register |

## Verification
The jump tests use a page register whose upper bits are nonzero. This shows whether only three bits reach the address, and whether the page comes from the register and not from the current counter. The move and add tests start from a counter whose bits 9:8 are both set, and use sums that do and do not carry out of bit 9. These patterns separate correct bit clearing and carry propagation from a plain byte add. The stack is driven through nested calls, an interrupt taken on top of a call, and seventeen pushes followed by seventeen pops. Together these expose ordering faults, pointer-wrap faults and return-value faults. Simultaneous strobes and strobes held while the enable is low check the priority order and the hold behaviour.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;

    // next-address source, chosen once per instruction cycle
    typedef enum logic [2:0] {
        SEL_HOLD = 3'd0,
        SEL_INC  = 3'd1,
        SEL_IRQ  = 3'd2,
        SEL_RET  = 3'd3,
        SEL_CALL = 3'd4,
        SEL_JMP  = 3'd5,
        SEL_MOV  = 3'd6,
        SEL_ADD  = 3'd7
    } pc_sel_e;

    // decoded flow-control strobes
    typedef struct packed {
        logic irq;
        logic ret;
        logic reti;
        logic call;
        logic jmp;
        logic ldpc;
        logic addpc;
    } strobe_t;

endpackage

// File: rtl/pgpc_sel.sv
module pgpc_sel
    import pgpc_pkg::*;
(
    input  logic    adv_i,
    input  strobe_t stb_i,
    output pc_sel_e sel_o
);

    always_comb begin
        sel_o = SEL_HOLD;
        if (adv_i) begin
            if (stb_i.irq)                      sel_o = SEL_IRQ;
            else if (stb_i.ret || stb_i.reti)   sel_o = SEL_RET;
            else if (stb_i.call)                sel_o = SEL_CALL;
            else if (stb_i.jmp)                 sel_o = SEL_JMP;
            else if (stb_i.ldpc)                sel_o = SEL_MOV;
            else if (stb_i.addpc)               sel_o = SEL_ADD;
            else                                sel_o = SEL_INC;
        end
    end

endmodule

// File: rtl/pgpc_stack.sv
module pgpc_stack #(
    parameter int DEPTH = 16,
    parameter int W     = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] top_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0]          sp;
        logic [DEPTH-1:0][W-1:0]   mem;
    } stk_t;

    stk_t st_d, st_q;
    logic [PTR_W-1:0] rd_idx;

    // the slot just below the pointer is the top entry; wraps when empty
    assign rd_idx = st_q.sp - PTR_W'(1);
    assign top_o  = st_q.mem[rd_idx];

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.mem[st_q.sp] = wdata_i;
            st_d.sp           = st_q.sp + PTR_W'(1);
        end else if (pop_i) begin
            st_d.sp = rd_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pgpc_shadow.sv
module pgpc_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         save_i,
    input  logic         restore_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] page_i,
    output logic         restore_o,
    output logic [W-1:0] acc_o,
    output logic [W-1:0] status_o,
    output logic [W-1:0] page_o
);

    typedef struct packed {
        logic [W-1:0] acc;
        logic [W-1:0] sts;
        logic [W-1:0] pg;
        logic         rst_pulse;
    } shd_t;

    shd_t sh_d, sh_q;

    always_comb begin
        sh_d           = sh_q;
        sh_d.rst_pulse = restore_i;
        if (save_i) begin
            sh_d.acc = acc_i;
            sh_d.sts = status_i;
            sh_d.pg  = page_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign restore_o = sh_q.rst_pulse;
    assign acc_o     = sh_q.acc;
    assign status_o  = sh_q.sts;
    assign page_o    = sh_q.pg;

endmodule

// File: rtl/pgpc_unit.sv
module pgpc_unit
    import pgpc_pkg::*;
#(
    parameter int            PC_W      = 13,
    parameter int            LOW_W     = 10,
    parameter int            DATA_W    = 8,
    parameter int            STK_DEPTH = 16,
    parameter logic [12:0]   VECTOR    = 13'h0008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              irq_i,
    input  logic              ret_i,
    input  logic              reti_i,
    input  logic              call_i,
    input  logic              jmp_i,
    input  logic              ldpc_i,
    input  logic              addpc_i,
    input  logic [LOW_W-1:0]  tgt_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] page_i,
    output logic [PC_W-1:0]   pc_o,
    output logic              restore_o,
    output logic [DATA_W-1:0] sh_acc_o,
    output logic [DATA_W-1:0] sh_status_o,
    output logic [DATA_W-1:0] sh_page_o
);

    localparam int PAGE_W = PC_W - LOW_W;
    localparam int CLR_LO = DATA_W;   // first of the two bits cleared by computed writes

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;

    strobe_t         stb;
    pc_sel_e         sel;
    pc_state_t       st_d, st_q;
    logic [PC_W-1:0] stk_top;
    logic [PC_W-1:0] stk_wdata;
    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] pc_page;
    logic [PC_W-1:0] pc_mov;
    logic [PC_W-1:0] pc_add;
    logic            do_push;
    logic            do_pop;

    assign stb = '{irq: irq_i, ret: ret_i, reti: reti_i, call: call_i,
                   jmp: jmp_i, ldpc: ldpc_i, addpc: addpc_i};

    pgpc_sel u_sel (
        .adv_i (adv_i),
        .stb_i (stb),
        .sel_o (sel)
    );

    // candidate addresses
    always_comb begin
        pc_inc  = st_q.pc + PC_W'(1);
        pc_page = {page_i[PAGE_W-1:0], tgt_i};
        pc_mov  = {st_q.pc[PC_W-1:DATA_W], acc_i};
        pc_mov[CLR_LO +: 2] = 2'b00;
        pc_add  = st_q.pc + PC_W'(acc_i);
        pc_add[CLR_LO +: 2] = 2'b00;
    end

    assign do_push   = (sel == SEL_IRQ) || (sel == SEL_CALL);
    assign do_pop    = (sel == SEL_RET);
    assign stk_wdata = (sel == SEL_IRQ) ? st_q.pc : pc_inc;

    always_comb begin
        st_d = st_q;
        case (sel)
            SEL_INC:  st_d.pc = pc_inc;
            SEL_IRQ:  st_d.pc = VECTOR[PC_W-1:0];
            SEL_RET:  st_d.pc = stk_top;
            SEL_CALL: st_d.pc = pc_page;
            SEL_JMP:  st_d.pc = pc_page;
            SEL_MOV:  st_d.pc = pc_mov;
            SEL_ADD:  st_d.pc = pc_add;
            default:  st_d.pc = st_q.pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pgpc_stack #(
        .DEPTH (STK_DEPTH),
        .W     (PC_W)
    ) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (do_push),
        .pop_i   (do_pop),
        .wdata_i (stk_wdata),
        .top_o   (stk_top)
    );

    pgpc_shadow #(
        .W (DATA_W)
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .save_i    (sel == SEL_IRQ),
        .restore_i ((sel == SEL_RET) && reti_i),
        .acc_i     (acc_i),
        .status_i  (status_i),
        .page_i    (page_i),
        .restore_o (restore_o),
        .acc_o     (sh_acc_o),
        .status_o  (sh_status_o),
        .page_o    (sh_page_o)
    );

    assign pc_o = st_q.pc;

endmodule

// File: rtl/pgpc_checker.sv
module pgpc_checker #(
    parameter int PC_W   = 13,
    parameter int LOW_W  = 10,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adv_i,
    input logic              irq_i,
    input logic              ret_i,
    input logic              reti_i,
    input logic              call_i,
    input logic              jmp_i,
    input logic              ldpc_i,
    input logic              addpc_i,
    input logic [LOW_W-1:0]  tgt_i,
    input logic [DATA_W-1:0] page_i,
    input logic [PC_W-1:0]   pc_o,
    input logic              restore_o
);

    localparam int PAGE_W = PC_W - LOW_W;

    logic no_stb;
    assign no_stb = !(irq_i || ret_i || reti_i || call_i || jmp_i || ldpc_i || addpc_i);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0) && !restore_o);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(pc_o));

    assert_increment_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && no_stb) |=> pc_o == PC_W'($past(pc_o) + PC_W'(1)));

    assert_jump_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && jmp_i && !irq_i && !ret_i && !reti_i && !call_i)
        |=> pc_o == {$past(page_i[PAGE_W-1:0]), $past(tgt_i)});

    assert_mov_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && (ldpc_i || addpc_i) && !irq_i && !ret_i && !reti_i && !call_i && !jmp_i)
        |=> pc_o[DATA_W +: 2] == 2'b00);

    assert_irq_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && irq_i) |=> pc_o == PC_W'(13'h0008));

    assert_restore_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restore_o) |-> $past(adv_i && reti_i && !irq_i));

endmodule

bind pgpc_unit pgpc_checker #(
    .PC_W   (PC_W),
    .LOW_W  (LOW_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_i     (adv_i),
    .irq_i     (irq_i),
    .ret_i     (ret_i),
    .reti_i    (reti_i),
    .call_i    (call_i),
    .jmp_i     (jmp_i),
    .ldpc_i    (ldpc_i),
    .addpc_i   (addpc_i),
    .tgt_i     (tgt_i),
    .page_i    (page_i),
    .pc_o      (pc_o),
    .restore_o (restore_o)
);

// File: tb/tb_pgpc_unit.sv
`timescale 1ns/1ps
module tb_pgpc_unit;

    localparam int S_IRQ = 0, S_RET = 1, S_RETI = 2, S_CALL = 3, S_JMP = 4, S_LDPC = 5, S_ADD = 6;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        adv_i = 0, irq_i = 0, ret_i = 0, reti_i = 0, call_i = 0, jmp_i = 0, ldpc_i = 0, addpc_i = 0;
    logic [9:0]  tgt_i = '0;
    logic [7:0]  acc_i = '0, status_i = '0, page_i = '0;
    logic [12:0] pc_o;
    logic        restore_o;
    logic [7:0]  sh_acc_o, sh_status_o, sh_page_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [12:0] exp_pc = '0;
    logic [12:0] mstk [16];
    int          msp = 0;
    logic [7:0]  exp_sa = '0, exp_ss = '0, exp_sp = '0;
    logic        exp_rst = 0;

    always #2.5 clk = ~clk;

    pgpc_unit dut (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .irq_i(irq_i), .ret_i(ret_i), .reti_i(reti_i),
        .call_i(call_i), .jmp_i(jmp_i), .ldpc_i(ldpc_i), .addpc_i(addpc_i), .tgt_i(tgt_i),
        .acc_i(acc_i), .status_i(status_i), .page_i(page_i), .pc_o(pc_o), .restore_o(restore_o),
        .sh_acc_o(sh_acc_o), .sh_status_o(sh_status_o), .sh_page_o(sh_page_o)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_stb(input logic [6:0] s);
        irq_i = s[S_IRQ]; ret_i = s[S_RET]; reti_i = s[S_RETI]; call_i = s[S_CALL];
        jmp_i = s[S_JMP]; ldpc_i = s[S_LDPC]; addpc_i = s[S_ADD];
    endtask

    // one instruction cycle; bench model follows the requirements
    task automatic drive(input logic [6:0] s, input logic [9:0] tgt, input logic [7:0] a,
                         input logic [7:0] st, input logic [7:0] pg, input string tag);
        logic [12:0] t;
        adv_i = 1; set_stb(s); tgt_i = tgt; acc_i = a; status_i = st; page_i = pg;
        exp_rst = 0;
        if (s[S_IRQ]) begin
            mstk[msp] = exp_pc; msp = (msp + 1) % 16;
            exp_pc = 13'h0008; exp_sa = a; exp_ss = st; exp_sp = pg;
        end else if (s[S_RET] || s[S_RETI]) begin
            msp = (msp + 15) % 16; exp_pc = mstk[msp];
            exp_rst = s[S_RETI];
        end else if (s[S_CALL]) begin
            mstk[msp] = exp_pc + 13'd1; msp = (msp + 1) % 16;
            exp_pc = {pg[2:0], tgt};
        end else if (s[S_JMP]) begin
            exp_pc = {pg[2:0], tgt};
        end else if (s[S_LDPC]) begin
            exp_pc = {exp_pc[12:10], 2'b00, a};
        end else if (s[S_ADD]) begin
            t = exp_pc + {5'd0, a};
            exp_pc = t & 13'h1CFF;
        end else begin
            exp_pc = exp_pc + 13'd1;
        end
        @(negedge clk);
        adv_i = 0; set_stb('0);
        chk(pc_o == exp_pc, tag, pc_o, exp_pc);
        chk(restore_o == exp_rst, {tag, " restore"}, restore_o, exp_rst);
    endtask

    task automatic t_reset;
        chk(pc_o == 13'h0, "R1 pc", pc_o, 0);
        chk(restore_o == 1'b0, "R1 restore", restore_o, 0);
        chk({sh_acc_o, sh_status_o, sh_page_o} == 24'h0, "R1 shadow", {sh_acc_o, sh_status_o, sh_page_o}, 0);
    endtask

    task automatic t_seq;
        for (int i = 0; i < 4; i++) drive(7'h0, 0, 0, 0, 0, "R2 increment");
        // strobes while adv low are ignored
        adv_i = 0; set_stb(7'b1011111); tgt_i = 10'h155; page_i = 8'h07;
        @(negedge clk);
        set_stb('0);
        chk(pc_o == exp_pc, "R2 hold with strobes", pc_o, exp_pc);
        chk(restore_o == 1'b0, "R2 hold restore", restore_o, 0);
        drive(7'b0010000, 10'h3FF, 0, 0, 8'h07, "R3 jump top");
        drive(7'h0, 0, 0, 0, 0, "R2 wrap to zero");
    endtask

    task automatic t_jump;
        drive(7'b0010000, 10'h123, 0, 0, 8'hFD, "R3 jump page5");
        drive(7'b0010000, 10'h001, 0, 0, 8'h02, "R3 jump page2");
    endtask

    task automatic t_call_ret;
        drive(7'b0010000, 10'h040, 0, 0, 8'h01, "R3 setup");
        drive(7'b0001000, 10'h200, 0, 0, 8'h03, "R4 call outer");
        drive(7'h0, 0, 0, 0, 0, "R2 inc in sub");
        drive(7'b0001000, 10'h010, 0, 0, 8'h06, "R4 call inner");
        drive(7'b0000010, 0, 0, 0, 0, "R5 ret inner");
        chk(pc_o == 13'h0E02, "R5 inner return address", pc_o, 13'h0E02);
        drive(7'b0000010, 0, 0, 0, 0, "R5 ret outer");
        chk(pc_o == 13'h0441, "R4 outer return address", pc_o, 13'h0441);
    endtask

    task automatic t_mov_add;
        drive(7'b0010000, 10'h3F0, 0, 0, 8'h06, "R3 setup 1BF0");
        drive(7'b0100000, 0, 8'h5A, 0, 0, "R6 mov");
        chk(pc_o == 13'h185A, "R6 mov clears 9:8", pc_o, 13'h185A);
        drive(7'b0010000, 10'h3F0, 0, 0, 8'h06, "R3 setup 1BF0 again");
        drive(7'b1000000, 0, 8'h20, 0, 0, "R7 add carry to page");
        chk(pc_o == 13'h1C10, "R7 carry into page", pc_o, 13'h1C10);
        drive(7'b0010000, 10'h105, 0, 0, 8'h00, "R3 setup 0105");
        drive(7'b1000000, 0, 8'h10, 0, 0, "R7 add clear 9:8");
        chk(pc_o == 13'h0015, "R7 bit 8 cleared", pc_o, 13'h0015);
    endtask

    task automatic t_irq;
        drive(7'b0010000, 10'h077, 0, 0, 8'h04, "R3 setup");
        drive(7'b0001000, 10'h300, 0, 0, 8'h02, "R4 call before irq");
        drive(7'b0011001, 10'h111, 8'hC3, 8'h5E, 8'hA5, "R8 irq over call/jump");
        chk(pc_o == 13'h0008, "R8 vector", pc_o, 13'h0008);
        chk(sh_acc_o == 8'hC3, "R9 shadow acc", sh_acc_o, 8'hC3);
        chk(sh_status_o == 8'h5E, "R9 shadow status", sh_status_o, 8'h5E);
        chk(sh_page_o == 8'hA5, "R9 shadow page", sh_page_o, 8'hA5);
        drive(7'h0, 0, 8'h11, 8'h22, 8'h33, "R2 inc in handler");
        drive(7'b0000100, 0, 8'h44, 8'h55, 8'h66, "R9 reti");
        chk(pc_o == 13'h0B00, "R8 resume interrupted address", pc_o, 13'h0B00);
        chk(sh_acc_o == 8'hC3, "R9 restored acc", sh_acc_o, 8'hC3);
        @(negedge clk);
        chk(restore_o == 1'b0, "R9 pulse one cycle", restore_o, 0);
        drive(7'b0000010, 0, 0, 0, 0, "R9 plain ret no pulse");
        chk(pc_o == 13'h1078, "R5 back from call", pc_o, 13'h1078);
    endtask

    task automatic t_priority;
        drive(7'b0010000, 10'h020, 0, 0, 8'h01, "R3 setup");
        drive(7'b0001000, 10'h050, 0, 0, 8'h02, "R10 call over jump");
        chk(pc_o == 13'h0850, "R10 call target", pc_o, 13'h0850);
        drive(7'b1111010, 10'h0AA, 8'h12, 0, 8'h05, "R10 ret over all");
        chk(pc_o == 13'h0421, "R10 ret wins", pc_o, 13'h0421);
        drive(7'b1110000, 10'h0AB, 8'h12, 0, 8'h05, "R10 jump over mov/add");
        drive(7'b1100000, 0, 8'h34, 0, 0, "R10 mov over add");
        chk(pc_o == 13'h1434, "R10 mov wins", pc_o, 13'h1434);
    endtask

    task automatic t_wrap;
        for (int i = 0; i < 17; i++)
            drive(7'b0001000, 10'(i * 3), 0, 0, 8'(i % 8), "R11 push");
        for (int i = 0; i < 17; i++)
            drive(7'b0000010, 0, 0, 0, 0, "R11 pop sequence");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mstk[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_seq();
        t_jump();
        t_call_ret();
        t_mov_add();
        t_irq();
        t_priority();
        t_wrap();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule